// File: doc/BRIEF.md
# Interleaved Pipelined Dot-Product Accumulator

This block sums a stream of two's-complement products on an adder whose result takes `STAGES` clock cycles to come back round. The latency is not hidden by stalling. The ring of adder stage registers holds `STAGES` independent partial sums. Every cycle the oldest partial sum leaves the last stage, passes through the adder, and re-enters the first stage. When a product is presented it is added on the way round. Otherwise zero is added.

When the caller raises `collapse_req`, the block runs a reduction that reuses the same adder and the same ring. The reduction has log2(`STAGES`) levels, and each level takes one full rotation of `STAGES` cycles. In a level with pairing distance h, the first h partial sums that leave the ring are each added to the partial sum h places behind them. The remaining slots of that rotation are refilled with zero. The pairing distance starts at `STAGES`/2 and halves after each level, so one slot ends up holding the total.

The total is then captured into `result` and flagged by a one-cycle `res_valid` pulse. `clear` empties the ring and the result. Without a clear, a new stream keeps adding onto the collapsed total. Sums wrap modulo 2^`DATA_W`. `STAGES` must be a power of two, at least 2.

The controller has three states:
- `ST_IDLE` accumulates and rotates the ring.
- `ST_REDUCE` runs the reduction levels.
- `ST_FINISH` holds the ring and captures the total.

The transitions are:
- `ST_IDLE` goes to `ST_REDUCE` when `collapse_req` is high and `clear` is low.
- `ST_REDUCE` goes to `ST_FINISH` on the last cycle of the last level.
- `ST_REDUCE` goes to `ST_IDLE` when `clear` aborts the reduction.
- `ST_FINISH` always goes to `ST_IDLE`.

Top module: `pipe_dot_accum`

## Requirements
- R1: After reset, `result` is 0 and both `res_valid` and `busy` are 0.
- R2: The collapsed result equals the sum, modulo 2^DATA_W, of every product accepted since the last clear. This holds for stream lengths of 1, below STAGES, equal to STAGES and above STAGES, with or without idle gaps between products.
- R3: When `collapse_req` is sampled high in idle without `clear`, `res_valid` rises on the (STAGES·log2(STAGES)+1)-th rising edge after the sampling edge.
- R4: `busy` is high from the edge that accepts a collapse until the edge that raises `res_valid`. `res_valid` lasts exactly one cycle and is never high together with `busy`.
- R5: A product presented while `busy` is high is ignored and does not enter any later result.
- R6: A `collapse_req` seen while `busy` is high is ignored and produces no extra result.
- R7: `clear` zeroes all partial sums and `result` in one cycle. A product presented in the same cycle as `clear` is dropped.
- R8: `clear` while `busy` is high aborts the reduction. `busy` is low on the next cycle and no result is produced.
- R9: `result` keeps its value until the next clear or the next captured total.
- R10: Without a clear, products accepted after a collapse are added onto the previously collapsed total.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clear | input | 1 | Zero the partial sums and the result |
| collapse_req | input | 1 | Start the reduction to one total |
| in_valid | input | 1 | `prod` carries a product this cycle |
| prod | input | DATA_W | Two's-complement product to accumulate |
| result | output | DATA_W | Last collapsed total |
| res_valid | output | 1 | One-cycle strobe when `result` is updated |
| busy | output | 1 | Reduction in progress; inputs other than `clear` ignored |

## Verification
The assertions assume `rst_n` is applied before any stimulus, and that `clear` is the only input that can end a busy period early. Any other input is legal in any cycle, including `collapse_req` and products while busy. The stimulus exercises exactly those cases: it drives noise products and repeated collapse requests during the reduction. It also aborts one reduction with `clear` and drops a product that coincides with a clear. All inputs change only on falling edges, so every sampled value is stable at the rising edge.

// File: rtl/pda_pkg.sv
package pda_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_REDUCE,
        ST_FINISH
    } pda_state_e;

    typedef enum logic [2:0] {
        OP_ROT,
        OP_ACC,
        OP_PAIR,
        OP_ZERO,
        OP_HOLD,
        OP_CLEAR
    } pda_op_e;

endpackage

// File: rtl/pda_ring.sv
module pda_ring
    import pda_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int STAGES = 4,
    localparam int IDX_W = $clog2(STAGES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  pda_op_e           op,
    input  logic [DATA_W-1:0] prod,
    input  logic [IDX_W-1:0]  half,
    output logic [DATA_W-1:0] tail
);

    logic [DATA_W-1:0] stage_q [STAGES];
    logic [DATA_W-1:0] operand_b;
    logic [DATA_W-1:0] entry;
    logic [IDX_W-1:0]  tap_idx;
    logic              shift_en;
    logic              zero_all;

    // Adder sits between the last stage and the first; the second operand is
    // either the product, a tap h slots behind the tail, or zero.
    always_comb begin
        tap_idx = IDX_W'(STAGES - 1) - half;
        unique case (op)
            OP_ACC:  operand_b = prod;
            OP_PAIR: operand_b = stage_q[tap_idx];
            default: operand_b = '0;
        endcase
        entry    = (op == OP_ZERO) ? '0 : stage_q[STAGES-1] + operand_b;
        shift_en = (op != OP_HOLD) && (op != OP_CLEAR);
        zero_all = (op == OP_CLEAR);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
        end else if (zero_all) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
        end else if (shift_en) begin
            stage_q[0] <= entry;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign tail = stage_q[STAGES-1];

endmodule

// File: rtl/pda_ctrl.sv
module pda_ctrl
    import pda_pkg::*;
#(
    parameter int STAGES = 4,
    localparam int IDX_W  = $clog2(STAGES),
    localparam int LEVELS = $clog2(STAGES),
    localparam int LVL_W  = $clog2(LEVELS) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             collapse_req,
    input  logic             in_valid,
    output pda_op_e          op,
    output logic [IDX_W-1:0] half,
    output logic             busy,
    output logic             capture
);

    pda_state_e       state_q;
    pda_state_e       state_d;
    logic [IDX_W-1:0] cyc_q;
    logic [LVL_W-1:0] lvl_q;
    logic             last_cyc;
    logic             last_lvl;

    assign last_cyc = (cyc_q == IDX_W'(STAGES - 1));
    assign last_lvl = (lvl_q == LVL_W'(LEVELS - 1));
    // Pairing distance halves every level: STAGES/2, STAGES/4, ... 1
    assign half     = IDX_W'(STAGES / 2) >> lvl_q;

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (!clear && collapse_req) state_d = ST_REDUCE;
            end
            ST_REDUCE: begin
                if (clear)                      state_d = ST_IDLE;
                else if (last_cyc && last_lvl)  state_d = ST_FINISH;
            end
            ST_FINISH: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Rotation and level counters, live only while reducing
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc_q <= '0;
            lvl_q <= '0;
        end else if (state_q != ST_REDUCE) begin
            cyc_q <= '0;
            lvl_q <= '0;
        end else begin
            cyc_q <= cyc_q + 1'b1;
            if (last_cyc) lvl_q <= lvl_q + 1'b1;
        end
    end

    // Outputs
    always_comb begin
        busy    = (state_q != ST_IDLE);
        capture = 1'b0;
        op      = OP_ROT;
        unique case (state_q)
            ST_IDLE: begin
                if (clear)         op = OP_CLEAR;
                else if (in_valid) op = OP_ACC;
                else               op = OP_ROT;
            end
            ST_REDUCE: begin
                if (clear)             op = OP_CLEAR;
                else if (cyc_q < half) op = OP_PAIR;
                else                   op = OP_ZERO;
            end
            ST_FINISH: begin
                op      = clear ? OP_CLEAR : OP_HOLD;
                capture = !clear;
            end
            default: op = OP_ROT;
        endcase
    end

endmodule

// File: rtl/pipe_dot_accum.sv
module pipe_dot_accum
    import pda_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int STAGES = 4,
    localparam int IDX_W = $clog2(STAGES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              collapse_req,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] prod,
    output logic [DATA_W-1:0] result,
    output logic              res_valid,
    output logic              busy
);

    pda_op_e           ring_op;
    logic [IDX_W-1:0]  half;
    logic              capture;
    logic [DATA_W-1:0] tail;

    pda_ctrl #(.STAGES(STAGES)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .clear        (clear),
        .collapse_req (collapse_req),
        .in_valid     (in_valid),
        .op           (ring_op),
        .half         (half),
        .busy         (busy),
        .capture      (capture)
    );

    pda_ring #(.DATA_W(DATA_W), .STAGES(STAGES)) u_ring (
        .clk   (clk),
        .rst_n (rst_n),
        .op    (ring_op),
        .prod  (prod),
        .half  (half),
        .tail  (tail)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result    <= '0;
            res_valid <= 1'b0;
        end else if (clear) begin
            result    <= '0;
            res_valid <= 1'b0;
        end else if (capture) begin
            result    <= tail;
            res_valid <= 1'b1;
        end else begin
            res_valid <= 1'b0;
        end
    end

endmodule

// File: rtl/pipe_dot_accum_chk.sv
module pipe_dot_accum_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clear,
    input logic              collapse_req,
    input logic [DATA_W-1:0] result,
    input logic              res_valid,
    input logic              busy
);

    // R4
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

    // R4
    valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> !busy);

    // R4
    busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && !$past(clear)) |-> res_valid);

    // R3
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && collapse_req && !clear) |=> busy);

    // R7
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (result == '0 && !res_valid));

    // R8
    clear_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !busy);

    // R9
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!res_valid && !$past(clear)) |-> $stable(result));

endmodule

bind pipe_dot_accum pipe_dot_accum_chk #(.DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .clear        (clear),
    .collapse_req (collapse_req),
    .result       (result),
    .res_valid    (res_valid),
    .busy         (busy)
);

// File: tb/pipe_dot_accum_test.sv
`timescale 1ns/1ps
module pipe_dot_accum_test;

    localparam int DATA_W = 32;
    localparam int STAGES = 4;
    localparam int LAT    = STAGES * $clog2(STAGES);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              clear = 1'b0;
    logic              collapse_req = 1'b0;
    logic              in_valid = 1'b0;
    logic [DATA_W-1:0] prod = '0;
    logic [DATA_W-1:0] result;
    logic              res_valid;
    logic              busy;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    logic [DATA_W-1:0] carry = '0;

    typedef struct {
        logic [DATA_W-1:0] sum;
        int                at;
    } item_t;
    item_t sb[$];

    pipe_dot_accum #(.DATA_W(DATA_W), .STAGES(STAGES)) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .clear        (clear),
        .collapse_req (collapse_req),
        .in_valid     (in_valid),
        .prod         (prod),
        .result       (result),
        .res_valid    (res_valid),
        .busy         (busy)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req,
                         input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, expv, cyc);
        end
    endtask

    // Monitor: pops the scoreboard on every result strobe (R2, R3, R4, R6, R8)
    always @(negedge clk) begin
        if (rst_n && res_valid) begin
            if (sb.size() == 0) begin
                checks++;
                errors++;
                $display("FAIL R6/R8 unexpected result actual=%0h expected=none", result);
            end else begin
                item_t it;
                it = sb.pop_front();
                check(result == it.sum, "R2 total", result, it.sum);
                check(cyc == it.at, "R3 latency", DATA_W'(cyc), DATA_W'(it.at));
                check(!busy, "R4 busy low at result", DATA_W'(busy), '0);
            end
        end
    end

    // Driver: streams n products, requests a collapse, pushes the expected total
    task automatic run_vec(input int n, input logic [DATA_W-1:0] base,
                           input logic [DATA_W-1:0] step, input int gap,
                           input bit do_clear, input bit noise);
        logic [DATA_W-1:0] sum;
        logic [DATA_W-1:0] val;
        int k;
        if (do_clear) begin
            @(negedge clk); clear = 1'b1;
            @(negedge clk); clear = 1'b0;
            carry = '0;
        end
        sum = carry;
        val = base;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            prod     = val;
            sum      = sum + val;
            val      = val + step;
            for (int g = 0; g < gap; g++) begin
                @(negedge clk);
                in_valid = 1'b0;
            end
        end
        @(negedge clk);
        in_valid     = 1'b0;
        collapse_req = 1'b1;
        k = cyc;
        sb.push_back('{sum, k + 2 + LAT});
        @(negedge clk);
        collapse_req = 1'b0;
        check(busy == 1'b1, "R4 busy after collapse", DATA_W'(busy), 1);
        if (noise) begin
            // R5 products and R6 collapse requests while busy are ignored
            for (int j = 0; j < 4; j++) begin
                in_valid     = 1'b1;
                prod         = 32'h0000_1000;
                collapse_req = (j == 1);
                @(negedge clk);
            end
            in_valid     = 1'b0;
            collapse_req = 1'b0;
        end
        while (busy) @(negedge clk);
        carry = sum;
        repeat (3) @(negedge clk);
        check(result == sum, "R9 result held", result, sum);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(result == '0, "R1 result", result, '0);
        check(res_valid == 1'b0, "R1 res_valid", DATA_W'(res_valid), '0);
        check(busy == 1'b0, "R1 busy", DATA_W'(busy), '0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2 length 1
        run_vec(1, 32'd7, 32'd0, 0, 1'b1, 1'b0);
        // R2 length below STAGES, negative values
        run_vec(3, -32'sd5, 32'd2, 0, 1'b1, 1'b0);
        // R2 length equal to STAGES, back to back
        run_vec(4, 32'd100, 32'd3, 0, 1'b1, 1'b0);
        // R2 above STAGES with gaps; R5 and R6 noise during busy
        run_vec(11, 32'd9, 32'd13, 1, 1'b1, 1'b1);
        // R10 continue onto the collapsed total
        run_vec(5, -32'sd40, 32'd7, 2, 1'b0, 1'b0);
        // R2 wrap modulo 2^DATA_W
        run_vec(6, 32'h7FFF_FFF0, 32'h1000_0000, 0, 1'b1, 1'b1);

        // R7 clear with a product in the same cycle
        @(negedge clk);
        clear = 1'b1; in_valid = 1'b1; prod = 32'd99;
        @(negedge clk);
        clear = 1'b0; in_valid = 1'b0;
        check(result == '0, "R7 result cleared", result, '0);
        carry = '0;
        run_vec(3, 32'd1, 32'd1, 0, 1'b0, 1'b0);

        // R8 abort a reduction with clear
        @(negedge clk);
        collapse_req = 1'b1;
        @(negedge clk);
        collapse_req = 1'b0;
        repeat (2) @(negedge clk);
        clear = 1'b1;
        @(negedge clk);
        clear = 1'b0;
        check(busy == 1'b0, "R8 busy after abort", DATA_W'(busy), '0);
        check(result == '0, "R8 result after abort", result, '0);
        carry = '0;
        repeat (LAT + 4) @(negedge clk);
        run_vec(9, 32'd500, -32'sd17, 2, 1'b0, 1'b1);

        repeat (5) @(negedge clk);
        check(sb.size() == 0, "R3 pending results", DATA_W'(sb.size()), '0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule